// File: doc/BRIEF.md
# Prescaled Multi-Channel Compare Timer

The block is a system timer built around one free-running 32-bit up-counter shared by four compare channels. The counter advances on ticks from an 8-bit prescaler, so the counting rate is the module clock divided by any integer from 1 to 256. Each channel holds a compare value, an enable bit and a sticky interrupt flag, and the flag drives that channel's own interrupt line. Software reaches every register, the counter included, over a simple 32-bit register bus with a single-cycle write strobe and a combinational read path.

A debug-halt input lets the counter stop while a debugger holds the system. The halt takes effect only when software has set the freeze bit in the control register. Because the counter never stops on a match, a channel left enabled matches again each time the counter wraps back round to its compare value.

The register bus is a control path. It has no back-pressure: a write is taken in the cycle `reg_wr` is high, and `reg_rdata` always shows the register selected by `reg_addr`. None of the block's pins carry a data stream, so there is no valid/ready interface.

Top module: `cmp_timer_top`

## Requirements
- R1: After reset every register reads zero and all interrupt outputs are low.
- R2: The control register at 0x00 has these fields: timer enable in bit 0, freeze-in-debug in bit 1, and prescale P in bits 15:8. It reads back what was written, and all other bits read zero.
- R3: While the timer is enabled and not frozen, the counter at 0x04 increments by one every P+1 clock cycles. It holds its value while the timer is disabled.
- R4: A write to 0x04 loads the counter, and the new value is visible in the next cycle. A load takes priority over an increment that falls due in the same cycle.
- R5: While the freeze bit is 1 and `debug_halt` is high, the counter and the prescaler phase both hold. When the freeze bit is 0, `debug_halt` has no effect.
- R6: A control write that changes P restarts the prescaler phase at zero. A write that leaves P unchanged does not disturb the phase.
- R7: Channel n has its enable at 0x10+0x10*n (bit 0), its flag at 0x14+0x10*n (bit 0) and its compare value at 0x18+0x10*n. The flag sets when the channel is enabled and the counter increments to a value equal to the compare value. `irq_o[n]` equals the flag.
- R8: A channel whose enable bit is 0 never sets its flag, whatever the counter does.
- R9: Writing 1 to bit 0 of a flag register clears that flag. Writing 0 leaves it unchanged.
- R10: If a flag set and a write-1 clear of that flag fall in the same cycle, the flag ends up set.
- R11: The counter keeps running after a match. It wraps from all ones to zero, and a channel that is still enabled matches again, including a compare value of zero reached at the wrap.
- R12: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| debug_halt | input | 1 | Debugger halt request; freezes the counter when the freeze bit is set |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr`; zero for unmapped offsets |
| irq_o | output | 4 | Per-channel interrupt, one bit per channel flag |

## Verification
The embedded assertions check the local rules on every cycle: the counter holds or steps by exactly one, a load wins over a step, the counter stays still under freeze, ticks are spaced when P is non-zero, and a flag changes only through a set, a write-1 clear or the set-over-clear rule. A flag can never rise on a disabled channel. Whole-register behaviours need the bench's scenarios, where a reference model is compared with the read port and the interrupt lines each cycle. These include the exact P+1 spacing across changes of P, the phase restart, a match at the counter wrap, the same-cycle set and clear, and unmapped offsets that neither store nor return data.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // register map (byte offsets)
  localparam int unsigned OFS_CTRL     = 32'h00;
  localparam int unsigned OFS_CNT      = 32'h04;
  localparam int unsigned CH_BASE      = 32'h10;
  localparam int unsigned CH_STRIDE    = 32'h10;
  localparam int unsigned CH_EN_OFS    = 32'h0;
  localparam int unsigned CH_FLAG_OFS  = 32'h4;
  localparam int unsigned CH_CMP_OFS   = 32'h8;
  // control field positions
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_FRZ_BIT = 1;
  localparam int unsigned CTRL_PSC_LSB = 8;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] phase;

  assign tick = run && (phase == psc);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (run)     phase <= tick ? '0 : phase + 1'b1;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psc != '0 && !restart) |=> !tick);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!tick || psc == '0));

  // R5
  frozen_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next
);
  assign cnt_next = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt_next;
  end

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));

  // R11
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_flag,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wdata,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt_next,
  output logic             en,
  output logic             flag,
  output logic [CNT_W-1:0] cmp
);
  logic hit, clr;

  assign hit = en && step && (cnt_next == cmp);
  assign clr = wr_flag && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      flag <= 1'b0;
      cmp  <= '0;
    end else begin
      if (wr_en)  en  <= wdata[0];
      if (wr_cmp) cmp <= wdata;
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && cnt_next == cmp) |=> flag);

  // R8
  flag_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(en));

  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && wdata[0] && !(en && step && cnt_next == cmp)) |=> !flag);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_flag && wdata[0]) && !(en && step && cnt_next == cmp)) |=> $stable(flag));
endmodule

// File: rtl/cmp_timer_top.sv
module cmp_timer_top
  import tmr_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              debug_halt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCH-1:0]    irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);

  logic             ctrl_en, ctrl_frz;
  logic [PSC_W-1:0] ctrl_psc;
  logic             wr_ctrl, wr_cnt, restart, run, tick;
  logic [CNT_W-1:0] cnt, cnt_next;

  logic [NCH-1:0]            ch_en, ch_flag;
  logic [NCH-1:0][CNT_W-1:0] ch_cmp;
  logic [NCH-1:0]            sel_en, sel_flag, sel_cmp;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_cnt  = reg_wr && (reg_addr == A_CNT);
  assign restart = wr_ctrl && (reg_wdata[CTRL_PSC_LSB +: PSC_W] != ctrl_psc);
  assign run     = ctrl_en && !(ctrl_frz && debug_halt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_frz <= 1'b0;
      ctrl_psc <= '0;
    end else if (wr_ctrl) begin
      ctrl_en  <= reg_wdata[CTRL_EN_BIT];
      ctrl_frz <= reg_wdata[CTRL_FRZ_BIT];
      ctrl_psc <= reg_wdata[CTRL_PSC_LSB +: PSC_W];
    end
  end

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .psc(ctrl_psc), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_cnt),
    .load_val(reg_wdata[CNT_W-1:0]), .cnt(cnt), .cnt_next(cnt_next)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE + g * CH_STRIDE);
    assign sel_en[g]   = (reg_addr == BASE + ADDR_W'(CH_EN_OFS));
    assign sel_flag[g] = (reg_addr == BASE + ADDR_W'(CH_FLAG_OFS));
    assign sel_cmp[g]  = (reg_addr == BASE + ADDR_W'(CH_CMP_OFS));

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr && sel_en[g]),
      .wr_flag(reg_wr && sel_flag[g]),
      .wr_cmp(reg_wr && sel_cmp[g]),
      .wdata(reg_wdata[CNT_W-1:0]),
      .step(tick), .cnt_next(cnt_next),
      .en(ch_en[g]), .flag(ch_flag[g]), .cmp(ch_cmp[g])
    );
  end

  assign irq_o = ch_flag;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[CTRL_EN_BIT]               = ctrl_en;
      reg_rdata[CTRL_FRZ_BIT]              = ctrl_frz;
      reg_rdata[CTRL_PSC_LSB +: PSC_W]     = ctrl_psc;
    end
    if (reg_addr == A_CNT) reg_rdata[CNT_W-1:0] = cnt;
    for (int i = 0; i < NCH; i++) begin
      if (sel_en[i])   reg_rdata[0] = ch_en[i];
      if (sel_flag[i]) reg_rdata[0] = ch_flag[i];
      if (sel_cmp[i])  reg_rdata[CNT_W-1:0] = ch_cmp[i];
    end
  end

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_frz && debug_halt && !wr_cnt) |=> $stable(cnt));

  // R3
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !wr_cnt) |=> $stable(cnt));
endmodule

// File: tb/cmp_timer_top_tb.sv
module cmp_timer_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        debug_halt = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_o;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";

  always #2ns clk = ~clk;  // 250 MHz

  cmp_timer_top u_dut (
    .clk(clk), .rst_n(rst_n), .debug_halt(debug_halt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // behavioural reference model
  logic        m_en, m_frz;
  logic [7:0]  m_psc;
  int          m_phase;
  logic [31:0] m_cnt;
  logic [3:0]  m_chen, m_flag;
  logic [31:0] m_cmp [4];

  function automatic logic [31:0] mread(input logic [7:0] a);
    logic [31:0] r = '0;
    if (a == 8'h00) r = {16'h0, m_psc, 6'h0, m_frz, m_en};
    if (a == 8'h04) r = m_cnt;
    for (int i = 0; i < 4; i++) begin
      if (a == 8'(16 + 16 * i)) r = {31'h0, m_chen[i]};
      if (a == 8'(20 + 16 * i)) r = {31'h0, m_flag[i]};
      if (a == 8'(24 + 16 * i)) r = m_cmp[i];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_frz = 0; m_psc = 0; m_phase = 0; m_cnt = 0;
      m_chen = 0; m_flag = 0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    end else begin
      bit run, tk;
      logic [31:0] stepped;
      run = m_en && !(m_frz && debug_halt);
      tk  = run && (m_phase == int'(m_psc));
      stepped = m_cnt + 1;
      for (int i = 0; i < 4; i++) begin
        bit hit, clr;
        hit = m_chen[i] && tk && (stepped == m_cmp[i]);
        clr = reg_wr && reg_addr == 8'(20 + 16 * i) && reg_wdata[0];
        if (hit) m_flag[i] = 1;
        else if (clr) m_flag[i] = 0;
        if (reg_wr && reg_addr == 8'(16 + 16 * i)) m_chen[i] = reg_wdata[0];
        if (reg_wr && reg_addr == 8'(24 + 16 * i)) m_cmp[i] = reg_wdata;
      end
      if (reg_wr && reg_addr == 8'h04) m_cnt = reg_wdata;
      else if (tk) m_cnt = stepped;
      if (reg_wr && reg_addr == 8'h00 && reg_wdata[15:8] != m_psc) m_phase = 0;
      else if (run) m_phase = tk ? 0 : m_phase + 1;
      if (reg_wr && reg_addr == 8'h00) begin
        m_en = reg_wdata[0]; m_frz = reg_wdata[1]; m_psc = reg_wdata[15:8];
      end
    end
  end

  task automatic compare();
    logic [31:0] er;
    er = mread(reg_addr);
    compared++;
    if (reg_rdata !== er) begin
      mismatched++;
      $display("FAIL %s rdata@%h actual=%h expected=%h", cur_req, reg_addr, reg_rdata, er);
    end
    compared++;
    if (irq_o !== m_flag) begin
      mismatched++;
      $display("FAIL %s irq actual=%b expected=%b", cur_req, irq_o, m_flag);
    end
  endtask

  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    compare();
    reg_wr = w; reg_addr = a; reg_wdata = d;
  endtask

  task automatic idle(input int n, input logic [7:0] a);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 32'h0);
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog (all) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state across the whole offset range
    cur_req = "R1";
    @(negedge clk);
    check_bit("R1", |irq_o, 1'b0);
    for (int i = 0; i < 20; i++) cyc(1'b0, 8'(4 * i), 32'h0);
    // R2: control layout and readback
    cur_req = "R2";
    cyc(1'b1, 8'h00, 32'hFFFF_0301);
    idle(2, 8'h00);
    // R3: prescaled counting, P=3
    cur_req = "R3";
    idle(20, 8'h04);
    // R6: change P restarts phase; same P does not
    cur_req = "R6";
    cyc(1'b1, 8'h00, 32'h0000_0001);
    idle(10, 8'h04);
    cyc(1'b1, 8'h00, 32'h0000_0501);
    idle(9, 8'h04);
    cyc(1'b1, 8'h00, 32'h0000_0501);
    idle(10, 8'h04);
    // R4: counter load, including priority over a due step
    cur_req = "R4";
    cyc(1'b1, 8'h04, 32'd100);
    idle(5, 8'h04);
    cyc(1'b1, 8'h00, 32'h0000_0001);
    cyc(1'b1, 8'h04, 32'h0000_1234);
    idle(3, 8'h04);
    // R7: two channels fire on their own lines
    cur_req = "R7";
    cyc(1'b1, 8'h18, 32'd300);
    cyc(1'b1, 8'h10, 32'd1);
    cyc(1'b1, 8'h38, 32'd305);
    cyc(1'b1, 8'h30, 32'd1);
    cyc(1'b1, 8'h04, 32'd290);
    idle(20, 8'h14);
    check_bit("R7", irq_o[0], 1'b1);
    check_bit("R7", irq_o[2], 1'b1);
    // R8: disabled channel with a reachable compare never fires
    cur_req = "R8";
    cyc(1'b1, 8'h28, 32'd300);
    cyc(1'b1, 8'h04, 32'd295);
    idle(10, 8'h24);
    check_bit("R8", irq_o[1], 1'b0);
    // R9: write 0 keeps, write 1 clears
    cur_req = "R9";
    cyc(1'b1, 8'h14, 32'h0);
    idle(2, 8'h14);
    check_bit("R9", irq_o[0], 1'b1);
    cyc(1'b1, 8'h14, 32'h1);
    cyc(1'b1, 8'h34, 32'h1);
    idle(3, 8'h14);
    check_bit("R9", irq_o[0], 1'b0);
    // R10: set and clear in the same cycle
    cur_req = "R10";
    cyc(1'b1, 8'h04, 32'd299);
    cyc(1'b1, 8'h14, 32'h1);
    cyc(1'b0, 8'h14, 32'h0);
    check_bit("R10", irq_o[0], 1'b1);
    idle(3, 8'h14);
    // R11: wrap and match at zero, counter keeps running
    cur_req = "R11";
    cyc(1'b1, 8'h48, 32'h0);
    cyc(1'b1, 8'h40, 32'h1);
    cyc(1'b1, 8'h04, 32'hFFFF_FFFC);
    idle(8, 8'h04);
    check_bit("R11", irq_o[3], 1'b1);
    // R5: freeze with halt holds; halt without freeze does not
    cur_req = "R5";
    cyc(1'b1, 8'h00, 32'h0000_0203);
    idle(4, 8'h04);
    debug_halt = 1'b1;
    idle(10, 8'h04);
    cyc(1'b1, 8'h00, 32'h0000_0201);
    idle(10, 8'h04);
    debug_halt = 1'b0;
    idle(3, 8'h04);
    // R3: disabled timer holds
    cur_req = "R3";
    cyc(1'b1, 8'h00, 32'h0000_0200);
    idle(6, 8'h04);
    // R12: unmapped offsets
    cur_req = "R12";
    cyc(1'b1, 8'h0C, 32'hFFFF_FFFF);
    cyc(1'b1, 8'h1C, 32'hFFFF_FFFF);
    cyc(1'b1, 8'h50, 32'hFFFF_FFFF);
    cyc(1'b0, 8'h0C, 32'h0);
    cyc(1'b0, 8'h1C, 32'h0);
    cyc(1'b0, 8'h50, 32'h0);
    for (int i = 0; i < 20; i++) cyc(1'b0, 8'(4 * i), 32'h0);
    @(negedge clk);
    compare();
    summary();
    $finish;
  end
endmodule